// File: doc/BRIEF.md
# Half-Page ECC Generator and Syndrome Checker

This block sits beside the byte lane that carries a 512-byte flash page between a controller and a card. While its enable bit is set it folds every data byte into one of two independent Hamming accumulators, one for each 256-byte half. Each accumulator produces a 3-byte check value made of line-parity pairs over the byte address and column-parity pairs over the bit position. On a page write, software freezes the accumulators and then reads the two check values so it can place them in the spare area.

On a page read, the six stored check bytes follow the 512 data bytes on the same lane. The block captures them, compares them with its own codes, and forms one 16-bit syndrome per half. A syndrome gives the byte and bit of a single flipped data bit, or marks the half as clean or as uncorrectable. A single ECC-access control bit turns dword reads of the data register into reads of these results. Applying the correction to the buffer is left to software.

Top module: `smEccEngine`

## Requirements
- R1: After reset both codes read as erased (0x00FFFFFF in write direction), and the read-direction word is 0x10001000.
- R2: A code is 24 bits. Bit 2k is the inverted parity of all bytes whose address bit k is 0, and bit 2k+1 is the same for address bit k = 1 (k = 0..7). Bit 16+2j is the inverted parity of data bits whose index bit j is 0, and bit 17+2j is the same for index bit j = 1 (j = 0..2). Bits 23:22 read 1. An all-ones half yields 0xFFFFFF, and readout bits 31:24 are 0.
- R3: With the enable bit low and the direction input low, each dword read (read strobe together with the access bit) returns the first-half code, then the second-half code, alternating. A strobe without the access bit does not advance the sequence.
- R4: With the direction input high, a read returns the first-half syndrome in bits 15:0 and the second-half syndrome in bits 31:16. In each syndrome, bits 7:0 hold the byte index, bits 10:8 the bit index, bit 12 flags no error, bit 13 flags correctable and bit 14 flags uncorrectable. Exactly one flag is set. A clean half reads 0x1000.
- R5: A single flipped data bit at byte b, bit i of a half gives that half the syndrome {0x20 | i, b}. The other half stays 0x1000.
- R6: Any other mismatch pattern, including two flipped data bits or one flipped stored-code bit, gives 0x4000 for that half.
- R7: A dword read in access mode while the enable bit is high clears both accumulators, the captured codes (to all ones), the byte counter and the readout sequence.
- R8: Bytes presented while the enable bit is low do not change either code.
- R9: Bytes 512 to 517 after a flush are taken as stored codes, low byte first, first half first. Later bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eccEnable | input | 1 | Accumulate when high; freeze when low |
| eccAccess | input | 1 | Redirects data-register dword reads to ECC results |
| rdStrobe | input | 1 | One-cycle dword read of the data register |
| dirRead | input | 1 | 1 = page read (syndrome readout), 0 = page write (code readout) |
| byteValid | input | 1 | A page byte is on byteData this cycle |
| byteData | input | 8 | Page byte |
| rdData | output | 32 | Result word for the current read |

## Verification
The assertions take for granted that bytes arrive only between a flush and the freeze, and that the direction input is steady while results are read out. Under those conditions exactly one syndrome flag is set, and an uncorrectable flag carries zero location fields. The stimulus always opens a page with a flush, holds the direction fixed for the whole page, and changes inputs only on the falling clock edge. Single-bit errors are swept over every bit of a spread of byte addresses in both halves, including the first and last byte of each half.

// File: rtl/smEccPkg.sv
package smEccPkg;
  localparam int CODE_BYTES = 3;
  localparam int CODE_W = 8 * CODE_BYTES;
  localparam int COL_PAIRS = 3;
  localparam int COL_BASE = 16;
  localparam int STORE_IDX_W = 3;

  typedef struct packed {
    logic clear;
    logic accum;
    logic half;
    logic store;
    logic [STORE_IDX_W-1:0] storeIdx;
    logic selHigh;
  } eccCtrlT;

  function automatic logic [7:0] colMask(input int j);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = ((i >> j) & 1) == 1;
    return m;
  endfunction
endpackage

// File: rtl/smEccCtrl.sv
module smEccCtrl
  import smEccPkg::*;
#(
  parameter int HALF_ADDR_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eccEnable,
  input  logic eccAccess,
  input  logic rdStrobe,
  input  logic byteValid,
  output eccCtrlT ctrl,
  output logic [HALF_ADDR_W-1:0] byteAddr
);
  localparam int HALF_BYTES = 1 << HALF_ADDR_W;
  localparam int CNT_W = HALF_ADDR_W + 2;
  localparam int DATA_END = 2 * HALF_BYTES;
  localparam int STORE_END = DATA_END + 2 * CODE_BYTES;

  logic [CNT_W-1:0] cnt;
  logic ptr;
  logic flush, readOut, take;

  assign flush = rdStrobe && eccAccess && eccEnable;
  assign readOut = rdStrobe && eccAccess && !eccEnable;
  assign take = byteValid && eccEnable && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ptr <= 1'b0;
    end else if (flush) begin
      cnt <= '0;
      ptr <= 1'b0;
    end else begin
      if (take && cnt != CNT_W'(STORE_END)) cnt <= cnt + 1'b1;
      if (readOut) ptr <= !ptr;
    end
  end

  always_comb begin
    ctrl.clear = flush;
    ctrl.accum = take && (cnt < CNT_W'(DATA_END));
    ctrl.half = cnt[HALF_ADDR_W];
    ctrl.store = take && (cnt >= CNT_W'(DATA_END)) && (cnt < CNT_W'(STORE_END));
    ctrl.storeIdx = STORE_IDX_W'(cnt - CNT_W'(DATA_END));
    ctrl.selHigh = ptr;
    byteAddr = cnt[HALF_ADDR_W-1:0];
  end
endmodule

// File: rtl/smEccData.sv
module smEccData
  import smEccPkg::*;
#(
  parameter int HALF_ADDR_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  eccCtrlT ctrl,
  input  logic [HALF_ADDR_W-1:0] byteAddr,
  input  logic [7:0] byteData,
  input  logic dirRead,
  output logic [1:0][CODE_W-1:0] codeOut,
  output logic [31:0] rdData
);
  localparam int AW = HALF_ADDR_W;

  logic bytePar;
  logic [COL_PAIRS-1:0] colOneIn, colZeroIn;
  logic [1:0][15:0] syndOut;

  assign bytePar = ^byteData;

  always_comb begin
    for (int j = 0; j < COL_PAIRS; j++) begin
      colOneIn[j] = ^(byteData & colMask(j));
      colZeroIn[j] = ^(byteData & ~colMask(j));
    end
  end

  for (genvar h = 0; h < 2; h++) begin : gHalf
    logic [AW-1:0] lineOne, lineZero;
    logic [COL_PAIRS-1:0] colOne, colZero;
    logic [CODE_W-1:0] refCode, code, diff;
    logic [STORE_IDX_W-1:0] slot;
    logic hit, allPairs, anyDiff;
    logic [7:0] byteIdx;
    logic [2:0] bitIdx;

    assign hit = ctrl.accum && (ctrl.half == 1'(h));
    assign slot = ctrl.storeIdx - STORE_IDX_W'(h * CODE_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lineOne <= '0;
        lineZero <= '0;
        colOne <= '0;
        colZero <= '0;
      end else if (ctrl.clear) begin
        lineOne <= '0;
        lineZero <= '0;
        colOne <= '0;
        colZero <= '0;
      end else if (hit) begin
        lineOne <= lineOne ^ (byteAddr & {AW{bytePar}});
        lineZero <= lineZero ^ (~byteAddr & {AW{bytePar}});
        colOne <= colOne ^ colOneIn;
        colZero <= colZero ^ colZeroIn;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) refCode <= '1;
      else if (ctrl.clear) refCode <= '1;
      else if (ctrl.store && slot < STORE_IDX_W'(CODE_BYTES))
        refCode[8*slot +: 8] <= byteData;
    end

    always_comb begin
      code = '1;
      for (int k = 0; k < AW; k++) begin
        code[2*k] = !lineZero[k];
        code[2*k+1] = !lineOne[k];
      end
      for (int j = 0; j < COL_PAIRS; j++) begin
        code[COL_BASE+2*j] = !colZero[j];
        code[COL_BASE+2*j+1] = !colOne[j];
      end
    end

    always_comb begin
      diff = refCode ^ code;
      allPairs = 1'b1;
      anyDiff = 1'b0;
      byteIdx = '0;
      bitIdx = '0;
      for (int k = 0; k < AW; k++) begin
        allPairs = allPairs && (diff[2*k] != diff[2*k+1]);
        anyDiff = anyDiff || diff[2*k] || diff[2*k+1];
        byteIdx[k] = diff[2*k+1];
      end
      for (int j = 0; j < COL_PAIRS; j++) begin
        allPairs = allPairs && (diff[COL_BASE+2*j] != diff[COL_BASE+2*j+1]);
        anyDiff = anyDiff || diff[COL_BASE+2*j] || diff[COL_BASE+2*j+1];
        bitIdx[j] = diff[COL_BASE+2*j+1];
      end
      if (!anyDiff) syndOut[h] = 16'h1000;
      else if (allPairs) syndOut[h] = {5'b00100, bitIdx, byteIdx};
      else syndOut[h] = 16'h4000;
    end

    assign codeOut[h] = code;
  end

  assign rdData = dirRead ? {syndOut[1], syndOut[0]}
                          : {8'h00, ctrl.selHigh ? codeOut[1] : codeOut[0]};
endmodule

// File: rtl/smEccEngine.sv
module smEccEngine
  import smEccPkg::*;
#(
  parameter int HALF_ADDR_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eccEnable,
  input  logic eccAccess,
  input  logic rdStrobe,
  input  logic dirRead,
  input  logic byteValid,
  input  logic [7:0] byteData,
  output logic [31:0] rdData
);
  eccCtrlT ctrl;
  logic [HALF_ADDR_W-1:0] byteAddr;
  logic [1:0][CODE_W-1:0] codeOut;
  logic [CODE_W-1:0] codeHalf0, codeHalf1;

  smEccCtrl #(.HALF_ADDR_W(HALF_ADDR_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .eccEnable(eccEnable), .eccAccess(eccAccess),
    .rdStrobe(rdStrobe), .byteValid(byteValid), .ctrl(ctrl), .byteAddr(byteAddr)
  );

  smEccData #(.HALF_ADDR_W(HALF_ADDR_W)) uData (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .byteAddr(byteAddr),
    .byteData(byteData), .dirRead(dirRead), .codeOut(codeOut), .rdData(rdData)
  );

  assign codeHalf0 = codeOut[0];
  assign codeHalf1 = codeOut[1];
endmodule

// File: rtl/smEccChecker.sv
module smEccChecker (
  input logic clk,
  input logic rst_n,
  input logic eccEnable,
  input logic eccAccess,
  input logic rdStrobe,
  input logic dirRead,
  input logic [31:0] rdData,
  input logic [23:0] code0,
  input logic [23:0] code1
);
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && eccAccess && eccEnable) |=> (code0 == 24'hFFFFFF && code1 == 24'hFFFFFF)); // R7

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !eccEnable |=> ($stable(code0) && $stable(code1))); // R8

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    dirRead |-> ($countones(rdData[14:12]) == 1 && $countones(rdData[30:28]) == 1)); // R4

  AST_UNCORR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dirRead && rdData[14]) |-> (rdData[10:0] == 11'h0)); // R6

  AST_CODE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    !dirRead |-> (rdData[31:24] == 8'h00 && rdData[23:22] == 2'b11)); // R2
endmodule

bind smEccEngine smEccChecker uChk (
  .clk(clk), .rst_n(rst_n), .eccEnable(eccEnable), .eccAccess(eccAccess),
  .rdStrobe(rdStrobe), .dirRead(dirRead), .rdData(rdData),
  .code0(codeHalf0), .code1(codeHalf1)
);

// File: tb/smEccEngine_test.sv
module smEccEngine_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eccEnable = 1'b0, eccAccess = 1'b0, rdStrobe = 1'b0, dirRead = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic [31:0] rdData;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [7:0] pg [512];
  logic [23:0] ref0, ref1;
  logic [31:0] w0, w1, w2;

  smEccEngine uut (.clk(clk), .rst_n(rst_n), .eccEnable(eccEnable), .eccAccess(eccAccess),
    .rdStrobe(rdStrobe), .dirRead(dirRead), .byteValid(byteValid), .byteData(byteData),
    .rdData(rdData));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expCode(input int h);
    logic [23:0] c = '1;
    for (int k = 0; k < 8; k++) begin
      logic p0 = 0, p1 = 0;
      for (int a = 0; a < 256; a++) begin
        logic par = ^pg[h*256+a];
        if (((a >> k) & 1) == 1) p1 ^= par; else p0 ^= par;
      end
      c[2*k] = ~p0; c[2*k+1] = ~p1;
    end
    for (int j = 0; j < 3; j++) begin
      logic q0 = 0, q1 = 0;
      for (int a = 0; a < 256; a++)
        for (int i = 0; i < 8; i++)
          if (((i >> j) & 1) == 1) q1 ^= pg[h*256+a][i]; else q0 ^= pg[h*256+a][i];
      c[16+2*j] = ~q0; c[17+2*j] = ~q1;
    end
    return c;
  endfunction

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); byteValid = 1'b1; byteData = b;
  endtask

  task automatic endBytes();
    @(negedge clk); byteValid = 1'b0;
  endtask

  task automatic readWord(output logic [31:0] w);
    @(negedge clk); eccAccess = 1'b1; rdStrobe = 1'b1;
    #1 w = rdData;
    @(negedge clk); eccAccess = 1'b0; rdStrobe = 1'b0;
  endtask

  task automatic flush();
    logic [31:0] d;
    @(negedge clk); eccEnable = 1'b1;
    readWord(d);
  endtask

  task automatic freeze();
    @(negedge clk); eccEnable = 1'b0;
  endtask

  task automatic writePage();
    dirRead = 1'b0;
    flush();
    for (int i = 0; i < 512; i++) sendByte(pg[i]);
    endBytes();
    freeze();
  endtask

  task automatic readPage(input logic [23:0] r0, input logic [23:0] r1, input int extra,
                          output logic [31:0] w);
    dirRead = 1'b1;
    flush();
    for (int i = 0; i < 512; i++) sendByte(pg[i]);
    for (int i = 0; i < 3; i++) sendByte(r0[8*i +: 8]);
    for (int i = 0; i < 3; i++) sendByte(r1[8*i +: 8]);
    for (int i = 0; i < extra; i++) sendByte(8'h00);
    endBytes();
    freeze();
    readWord(w);
  endtask

  task automatic fillPattern();
    for (int i = 0; i < 512; i++) pg[i] = 8'((i * 37 + 5) ^ (i >> 3));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int offs [8];
    offs = '{0, 1, 2, 85, 127, 128, 170, 255};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R1 reset code", rdData, 32'h00FFFFFF);
    dirRead = 1'b1;
    #1 check("R1 reset syndrome", rdData, 32'h10001000);

    // R2 R3: code readout order
    fillPattern();
    writePage();
    readWord(w0); readWord(w1); readWord(w2);
    check("R2 R3 first code", w0, {8'h00, expCode(0)});
    check("R2 R3 second code", w1, {8'h00, expCode(1)});
    check("R3 wraps to first", w2, w0);
    @(negedge clk); rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0;
    readWord(w2);
    check("R3 strobe without access ignored", w2, w1);

    // R8: frozen accumulators
    writePage();
    for (int i = 0; i < 20; i++) sendByte(8'(i * 13));
    endBytes();
    readWord(w0); readWord(w1);
    check("R8 first code frozen", w0, {8'h00, expCode(0)});
    check("R8 second code frozen", w1, {8'h00, expCode(1)});

    // R7: flush clears
    flush(); freeze();
    readWord(w0); readWord(w1);
    check("R7 first code cleared", w0, 32'h00FFFFFF);
    check("R7 second code cleared", w1, 32'h00FFFFFF);

    // R2: erased page
    for (int i = 0; i < 512; i++) pg[i] = 8'hFF;
    writePage();
    readWord(w0); readWord(w1);
    check("R2 erased first", w0, 32'h00FFFFFF);
    check("R2 erased second", w1, 32'h00FFFFFF);

    // R4 R9: clean read, then extra trailing bytes
    fillPattern();
    ref0 = expCode(0); ref1 = expCode(1);
    readPage(ref0, ref1, 0, w0);
    check("R4 R9 clean read", w0, 32'h10001000);
    readPage(ref0, ref1, 12, w0);
    check("R9 trailing bytes ignored", w0, 32'h10001000);

    // R5: single-bit sweep
    for (int h = 0; h < 2; h++)
      for (int o = 0; o < 8; o++)
        for (int b = 0; b < 8; b++) begin
          logic [15:0] s;
          fillPattern();
          pg[h*256+offs[o]][b] = ~pg[h*256+offs[o]][b];
          readPage(ref0, ref1, 0, w0);
          s = {8'h20 | 8'(b), 8'(offs[o])};
          check("R5 single bit", w0, h == 0 ? {16'h1000, s} : {s, 16'h1000});
        end

    // R6: double error and stored-code error
    fillPattern();
    pg[3][1] = ~pg[3][1];
    pg[9][1] = ~pg[9][1];
    readPage(ref0, ref1, 0, w0);
    check("R6 double error", w0, 32'h10004000);
    fillPattern();
    readPage(ref0, ref1 ^ 24'h000001, 0, w0);
    check("R6 stored code error", w0, 32'h40001000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule